// File: doc/BRIEF.md
# Lane Margin Sweep Controller

This block runs a receiver margining sweep on one lane while the link keeps carrying traffic. Software selects an axis and a direction, an error budget, a step ceiling, a dwell length and a run-time budget, and then pulses start. The controller moves the receiver sampler away from its operating point one step at a time. At each step it waits through a dwell window and accumulates the errors reported for that step. It stops as soon as the errors reach the budget or the step ceiling is passed cleanly.

The sweep can also end through a software abort or an expired run-time budget. In every case the sampler offset returns to zero and the offset-apply strobe drops, so the receiver goes back to the settings it had before margining. The controller then reports the last step that passed and a status code.

Errors come either from an independent error sampler or, when the receiver has none, from the sum of parity-error pulses and recovery-entry pulses. Voltage sweeps need the receiver's voltage capability bit. Without it they are refused at once.

Top module: `margin_sweep_ctl`

## Requirements
- R1: During a sweep `samp_apply_o` is 1 and `samp_dir_o` holds the latched direction. `samp_offset_o` starts at 1 and rises by exactly one at each step advance.
- R2: Direction, error limit, step ceiling, dwell and budget are latched on the accepted start. Changes on those inputs during the sweep have no effect on the outcome.
- R3: The per-step error count is cleared at every step start. Each sweep cycle adds `ind_err_i` when `cap_ind_i`=1, and otherwise `parity_err_i`+`recov_entry_i`. The sweep fails in the first cycle where the count is nonzero and reaches the limit, so a limit of 0 acts as 1.
- R4: A failure ends the sweep with status 1 (fail found) and `margin_o` = failing step − 1.
- R5: Each step lasts max(dwell,1) cycles, and errors are counted in each of those cycles.
- R6: The effective ceiling is min(`step_ceil_i`, `cap_tsteps_i` for directions 0/1 or `cap_vsteps_i` for directions 2/3). If the last cycle of the ceiling step passes, the sweep ends with status 2 (no fail found) and `margin_o` = ceiling. A ceiling of 0 ends at once with status 2 and margin 0.
- R7: Directions are 0 time left, 1 time right, 2 voltage up, 3 voltage down. A start with direction 2 or 3 while `cap_volt_i`=0 is refused: status 5, margin 0, and the sampler never moves.
- R8: Whenever `busy_o`=0, `samp_offset_o`=0 and `samp_apply_o`=0. `done_o` pulses for one cycle with `busy_o`=0 at the end of every sweep, including a refused one.
- R9: A start pulse while busy is ignored.
- R10: `abort_i` during a sweep ends it with status 3 and `margin_o` = current step − 1. It takes priority over every other ending.
- R11: With `budget_i` ≠ 0, a sweep still running in its budget-th cycle ends in that cycle with status 4 and `margin_o` = current step − 1. This ending takes priority over failure and ceiling. A budget of 0 disables the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request pulse |
| abort_i | input | 1 | Software abort request |
| dir_i | input | 2 | Sweep direction code |
| err_limit_i | input | ERR_W | Error count limit |
| step_ceil_i | input | STEP_W | Software step ceiling |
| dwell_i | input | DWELL_W | Dwell cycles per step |
| budget_i | input | BUDGET_W | Run-time cycle budget, 0 = unlimited |
| cap_volt_i | input | 1 | Receiver supports voltage margining |
| cap_ind_i | input | 1 | Receiver has an independent error sampler |
| cap_tsteps_i | input | STEP_W | Receiver timing step count |
| cap_vsteps_i | input | STEP_W | Receiver voltage step count |
| parity_err_i | input | 1 | Parity error pulse |
| recov_entry_i | input | 1 | Recovery-state entry pulse |
| ind_err_i | input | 1 | Independent sampler error pulse |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle end-of-sweep pulse |
| status_o | output | 3 | Result code (0 none, 1 fail, 2 no fail, 3 aborted, 4 timeout, 5 refused) |
| margin_o | output | STEP_W | Last passing step |
| samp_offset_o | output | STEP_W | Offset magnitude sent to the sampler |
| samp_dir_o | output | 2 | Direction sent to the sampler |
| samp_apply_o | output | 1 | Offset applied to the sampler |

## Verification
The hardest situations to reach are the collisions at one edge. These include a failure in the last dwell cycle of the ceiling step, or a budget expiring in the same cycle as a failure. Both outcomes depend on the exact priority between endings.

The random sweeps reach them with an error probability that grows with the step number. Each sweep has its own dwell, ceiling, limit and a sometimes-small budget, so ends land on many cycle positions. A bench model, built from the requirements, replays the exact error pattern and predicts the ending cycle, the status and the margin. During every sweep the configuration inputs are scrambled each cycle and stray start pulses are injected.

// File: rtl/msweep_pkg.sv
package msweep_pkg;

   typedef enum logic [1:0] {
      DIR_TLEFT  = 2'd0,
      DIR_TRIGHT = 2'd1,
      DIR_VUP    = 2'd2,
      DIR_VDOWN  = 2'd3
   } sweep_dir_e;

   typedef enum logic [2:0] {
      ST_NONE    = 3'd0,
      ST_FAIL    = 3'd1,
      ST_NOFAIL  = 3'd2,
      ST_ABORT   = 3'd3,
      ST_TIMEOUT = 3'd4,
      ST_REFUSED = 3'd5
   } sweep_stat_e;

   typedef enum logic {
      S_IDLE = 1'b0,
      S_RUN  = 1'b1
   } seq_state_e;

   function automatic logic dir_is_volt(input logic [1:0] d);
      return d[1];
   endfunction

endpackage

// File: rtl/msweep_err_acc.sv
module msweep_err_acc #(
   parameter int ERR_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             en_i,
   input  logic             cap_ind_i,
   input  logic             par_i,
   input  logic             rec_i,
   input  logic             ind_i,
   output logic [ERR_W-1:0] acc_o,
   output logic [ERR_W-1:0] acc_nxt_o
);
   localparam logic [ERR_W-1:0] ACC_MAX = '1;

   logic [1:0]       inc;
   logic [ERR_W:0]   sum;
   logic [ERR_W-1:0] acc_q;

   always_comb begin
      inc = cap_ind_i ? {1'b0, ind_i} : ({1'b0, par_i} + {1'b0, rec_i});
      sum = {1'b0, acc_q} + {{(ERR_W-1){1'b0}}, inc};
   end

   generate
      if (ERR_W < 2) begin : g_bad_w
         $error("msweep_err_acc: ERR_W must be at least 2");
      end
      if (SATURATE) begin : g_sat
         assign acc_nxt_o = sum[ERR_W] ? ACC_MAX : sum[ERR_W-1:0];
      end else begin : g_wrap
         assign acc_nxt_o = sum[ERR_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       acc_q <= '0;
      else if (clear_i) acc_q <= '0;
      else if (en_i)    acc_q <= acc_nxt_o;
   end

   assign acc_o = acc_q;

   // R3: count restarts from zero after every step start
   p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> acc_o == '0);

   // R3: while accumulating the count never goes down
   p_monotone_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !clear_i && SATURATE) |=> acc_o >= $past(acc_o));

endmodule

// File: rtl/msweep_wdog.sv
module msweep_wdog #(
   parameter int BUDGET_W = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr_i,
   input  logic                run_i,
   input  logic [BUDGET_W-1:0] budget_i,
   output logic                expire_o
);
   logic [BUDGET_W-1:0] cnt_q;
   logic [BUDGET_W:0]   cnt_inc;

   generate
      if (BUDGET_W < 2) begin : g_bad_w
         $error("msweep_wdog: BUDGET_W must be at least 2");
      end
   endgenerate

   assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
   assign expire_o = run_i && (budget_i != '0) && (cnt_inc >= {1'b0, budget_i});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q <= '0;
      else if (clr_i)              cnt_q <= '0;
      else if (run_i && !(&cnt_q)) cnt_q <= cnt_inc[BUDGET_W-1:0];
   end

   // R11: the running count advances by one per sweep cycle until expiry
   p_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !clr_i && !expire_o && !(&cnt_q)) |=> cnt_q == $past(cnt_q) + 1'b1);

   // R11: a disabled budget never expires
   p_nodisable_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (budget_i == '0) |-> !expire_o);

endmodule

// File: rtl/msweep_seq.sv
module msweep_seq
   import msweep_pkg::*;
#(
   parameter int STEP_W   = 6,
   parameter int ERR_W    = 8,
   parameter int DWELL_W  = 4,
   parameter int BUDGET_W = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic                abort_i,
   input  logic [1:0]          dir_i,
   input  logic [ERR_W-1:0]    limit_i,
   input  logic [STEP_W-1:0]   ceil_i,
   input  logic [DWELL_W-1:0]  dwell_i,
   input  logic [BUDGET_W-1:0] budget_i,
   input  logic                cap_volt_i,
   input  logic [STEP_W-1:0]   cap_tsteps_i,
   input  logic [STEP_W-1:0]   cap_vsteps_i,
   input  logic [ERR_W-1:0]    acc_nxt_i,
   input  logic                expire_i,
   output logic                busy_o,
   output logic                done_o,
   output logic [2:0]          status_o,
   output logic [STEP_W-1:0]   margin_o,
   output logic [STEP_W-1:0]   offset_o,
   output logic [1:0]          dir_o,
   output logic                apply_o,
   output logic                acc_clr_o,
   output logic                acc_en_o,
   output logic                wd_clr_o,
   output logic [BUDGET_W-1:0] budget_o
);
   seq_state_e          state_q;
   logic [STEP_W-1:0]   step_q, ceil_q, offset_q, margin_q;
   logic [DWELL_W-1:0]  dwell_q, dwell_cfg_q;
   logic [ERR_W-1:0]    limit_q;
   logic [BUDGET_W-1:0] budget_q;
   logic [1:0]          dir_q;
   sweep_stat_e         status_q;
   logic                apply_q, done_q;

   logic                run, last_dwell, fail, adv, end_now, refuse;
   logic [STEP_W-1:0]   cap_sel, ceil_new, end_margin;
   sweep_stat_e         end_stat;

   always_comb begin
      run        = (state_q == S_RUN);
      cap_sel    = dir_is_volt(dir_i) ? cap_vsteps_i : cap_tsteps_i;
      ceil_new   = (ceil_i < cap_sel) ? ceil_i : cap_sel;
      refuse     = dir_is_volt(dir_i) && !cap_volt_i;
      last_dwell = ({1'b0, dwell_q} + 1'b1) >= {1'b0, dwell_cfg_q};
      fail       = (acc_nxt_i != '0) && (acc_nxt_i >= limit_q);
      end_now    = 1'b0;
      adv        = 1'b0;
      end_stat   = ST_NONE;
      end_margin = step_q - 1'b1;
      if (run) begin
         if (abort_i) begin
            end_now = 1'b1; end_stat = ST_ABORT;
         end else if (expire_i) begin
            end_now = 1'b1; end_stat = ST_TIMEOUT;
         end else if (fail) begin
            end_now = 1'b1; end_stat = ST_FAIL;
         end else if (last_dwell) begin
            if (step_q == ceil_q) begin
               end_now = 1'b1; end_stat = ST_NOFAIL; end_margin = ceil_q;
            end else begin
               adv = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= S_IDLE;
         step_q      <= '0;
         ceil_q      <= '0;
         offset_q    <= '0;
         margin_q    <= '0;
         dwell_q     <= '0;
         dwell_cfg_q <= '0;
         limit_q     <= '0;
         budget_q    <= '0;
         dir_q       <= '0;
         status_q    <= ST_NONE;
         apply_q     <= 1'b0;
         done_q      <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!run && start_i) begin
            dir_q       <= dir_i;
            limit_q     <= limit_i;
            ceil_q      <= ceil_new;
            dwell_cfg_q <= dwell_i;
            budget_q    <= budget_i;
            dwell_q     <= '0;
            if (refuse || ceil_new == '0) begin
               status_q <= refuse ? ST_REFUSED : ST_NOFAIL;
               margin_q <= '0;
               done_q   <= 1'b1;
            end else begin
               state_q  <= S_RUN;
               step_q   <= {{(STEP_W-1){1'b0}}, 1'b1};
               offset_q <= {{(STEP_W-1){1'b0}}, 1'b1};
               apply_q  <= 1'b1;
               status_q <= ST_NONE;
            end
         end else if (end_now) begin
            state_q  <= S_IDLE;
            offset_q <= '0;
            apply_q  <= 1'b0;
            status_q <= end_stat;
            margin_q <= end_margin;
            done_q   <= 1'b1;
         end else if (adv) begin
            step_q   <= step_q + 1'b1;
            offset_q <= offset_q + 1'b1;
            dwell_q  <= '0;
         end else if (run) begin
            dwell_q  <= dwell_q + 1'b1;
         end
      end
   end

   assign busy_o    = run;
   assign done_o    = done_q;
   assign status_o  = status_q;
   assign margin_o  = margin_q;
   assign offset_o  = offset_q;
   assign dir_o     = dir_q;
   assign apply_o   = apply_q;
   assign acc_clr_o = !run || last_dwell;
   assign acc_en_o  = run;
   assign wd_clr_o  = !run;
   assign budget_o  = budget_q;

   // R8: sampler back at its pre-margin settings whenever idle
   p_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (offset_q == '0 && !apply_q));

   // R1: offset only ever moves up by a single step while sweeping
   p_step_inc_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && offset_q != $past(offset_q)) |-> offset_q == $past(offset_q) + 1'b1);

   // R2: latched configuration is frozen for the whole sweep
   p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run)) |-> ($stable(limit_q) && $stable(dir_q) && $stable(ceil_q)));

   // R6: offset stays inside 1..ceiling
   p_ceil_r6: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (offset_q != '0 && offset_q <= ceil_q));

   // R7: unsupported voltage sweep never enters the running state
   p_refuse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && start_i && dir_i[1] && !cap_volt_i) |=> (!run && status_q == ST_REFUSED));

   // R10: abort wins over every other ending
   p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (run && abort_i) |=> (!run && status_q == ST_ABORT));

   // R9: a start seen while running leaves the direction untouched
   p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (run && start_i) |=> $stable(dir_q));

endmodule

// File: rtl/margin_sweep_ctl.sv
module margin_sweep_ctl
   import msweep_pkg::*;
#(
   parameter int STEP_W   = 6,
   parameter int ERR_W    = 8,
   parameter int DWELL_W  = 4,
   parameter int BUDGET_W = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic                abort_i,
   input  logic [1:0]          dir_i,
   input  logic [ERR_W-1:0]    err_limit_i,
   input  logic [STEP_W-1:0]   step_ceil_i,
   input  logic [DWELL_W-1:0]  dwell_i,
   input  logic [BUDGET_W-1:0] budget_i,
   input  logic                cap_volt_i,
   input  logic                cap_ind_i,
   input  logic [STEP_W-1:0]   cap_tsteps_i,
   input  logic [STEP_W-1:0]   cap_vsteps_i,
   input  logic                parity_err_i,
   input  logic                recov_entry_i,
   input  logic                ind_err_i,
   output logic                busy_o,
   output logic                done_o,
   output logic [2:0]          status_o,
   output logic [STEP_W-1:0]   margin_o,
   output logic [STEP_W-1:0]   samp_offset_o,
   output logic [1:0]          samp_dir_o,
   output logic                samp_apply_o
);
   generate
      if (STEP_W < 1 || DWELL_W < 1) begin : g_bad_cfg
         $error("margin_sweep_ctl: STEP_W and DWELL_W must be positive");
      end
   endgenerate

   logic [ERR_W-1:0]    acc, acc_nxt;
   logic                acc_clr, acc_en, wd_clr, expire;
   logic [BUDGET_W-1:0] budget_lat;

   msweep_seq #(
      .STEP_W(STEP_W), .ERR_W(ERR_W), .DWELL_W(DWELL_W), .BUDGET_W(BUDGET_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
      .dir_i(dir_i), .limit_i(err_limit_i), .ceil_i(step_ceil_i),
      .dwell_i(dwell_i), .budget_i(budget_i), .cap_volt_i(cap_volt_i),
      .cap_tsteps_i(cap_tsteps_i), .cap_vsteps_i(cap_vsteps_i),
      .acc_nxt_i(acc_nxt), .expire_i(expire),
      .busy_o(busy_o), .done_o(done_o), .status_o(status_o),
      .margin_o(margin_o), .offset_o(samp_offset_o), .dir_o(samp_dir_o),
      .apply_o(samp_apply_o), .acc_clr_o(acc_clr), .acc_en_o(acc_en),
      .wd_clr_o(wd_clr), .budget_o(budget_lat)
   );

   msweep_err_acc #(.ERR_W(ERR_W), .SATURATE(1'b1)) u_acc (
      .clk(clk), .rst_n(rst_n), .clear_i(acc_clr), .en_i(acc_en),
      .cap_ind_i(cap_ind_i), .par_i(parity_err_i), .rec_i(recov_entry_i),
      .ind_i(ind_err_i), .acc_o(acc), .acc_nxt_o(acc_nxt)
   );

   msweep_wdog #(.BUDGET_W(BUDGET_W)) u_wdog (
      .clk(clk), .rst_n(rst_n), .clr_i(wd_clr), .run_i(acc_en),
      .budget_i(budget_lat), .expire_o(expire)
   );

   // R8: the end pulse is only ever seen with the sweep finished
   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R3: an error count is never carried in while idle
   p_idle_acc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && $past(!busy_o)) |-> acc == '0);

endmodule

// File: tb/margin_sweep_ctl_test.sv
module margin_sweep_ctl_test;
   localparam int CLK_P    = 10;
   localparam int STEP_W   = 6;
   localparam int ERR_W    = 8;
   localparam int DWELL_W  = 4;
   localparam int BUDGET_W = 12;
   localparam int MAXK     = 1100;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start_i = 0, abort_i = 0, cap_volt_i = 0, cap_ind_i = 0;
   logic parity_err_i = 0, recov_entry_i = 0, ind_err_i = 0;
   logic [1:0] dir_i = '0;
   logic [ERR_W-1:0] err_limit_i = '0;
   logic [STEP_W-1:0] step_ceil_i = '0, cap_tsteps_i = '0, cap_vsteps_i = '0;
   logic [DWELL_W-1:0] dwell_i = '0;
   logic [BUDGET_W-1:0] budget_i = '0;
   logic busy_o, done_o, samp_apply_o;
   logic [2:0] status_o;
   logic [STEP_W-1:0] margin_o, samp_offset_o;
   logic [1:0] samp_dir_o;

   int checks = 0, fails = 0;
   bit finished = 0;
   bit par_a [0:MAXK];
   bit rec_a [0:MAXK];
   bit ind_a [0:MAXK];
   int abort_at = 0, bstart_at = 0;
   int exp_stat, exp_margin, exp_end;

   margin_sweep_ctl #(.STEP_W(STEP_W), .ERR_W(ERR_W), .DWELL_W(DWELL_W), .BUDGET_W(BUDGET_W)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i), .dir_i(dir_i),
      .err_limit_i(err_limit_i), .step_ceil_i(step_ceil_i), .dwell_i(dwell_i),
      .budget_i(budget_i), .cap_volt_i(cap_volt_i), .cap_ind_i(cap_ind_i),
      .cap_tsteps_i(cap_tsteps_i), .cap_vsteps_i(cap_vsteps_i),
      .parity_err_i(parity_err_i), .recov_entry_i(recov_entry_i), .ind_err_i(ind_err_i),
      .busy_o(busy_o), .done_o(done_o), .status_o(status_o), .margin_o(margin_o),
      .samp_offset_o(samp_offset_o), .samp_dir_o(samp_dir_o), .samp_apply_o(samp_apply_o));

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic string stat_req(input int s);
      case (s)
         1: return "R4";
         2: return "R6";
         3: return "R10";
         4: return "R11";
         5: return "R7";
         default: return "R8";
      endcase
   endfunction

   // reference outcome computed from the requirements
   task automatic model(input int d, lim, csw, dw, bud, cv, ci, ts, vs);
      int ce, s, acc, w, deff;
      ce = (d >= 2) ? vs : ts;
      if (csw < ce) ce = csw;
      deff = (dw == 0) ? 1 : dw;
      exp_end = 0; exp_margin = 0;
      if (d >= 2 && cv == 0) begin exp_stat = 5; return; end
      if (ce == 0) begin exp_stat = 2; return; end
      s = 1; acc = 0; w = 0;
      for (int k = 1; k <= MAXK; k++) begin
         exp_end = k; exp_margin = s - 1;
         if (abort_at == k) begin exp_stat = 3; return; end
         if (bud != 0 && k >= bud) begin exp_stat = 4; return; end
         acc += ci ? int'(ind_a[k]) : (int'(par_a[k]) + int'(rec_a[k]));
         if (acc > 255) acc = 255;
         if (acc != 0 && acc >= lim) begin exp_stat = 1; return; end
         w++;
         if (w >= deff) begin
            if (s == ce) begin exp_stat = 2; exp_margin = ce; return; end
            s++; acc = 0; w = 0;
         end
      end
      exp_stat = 0;
   endtask

   task automatic sweep(input int d, lim, csw, dw, bud, cv, ci, ts, vs, input bit scramble, input string tag);
      int k, deff, se, bad_act, bad_exp;
      bit trk_bad;
      model(d, lim, csw, dw, bud, cv, ci, ts, vs);
      deff = (dw == 0) ? 1 : dw;
      @(negedge clk);
      dir_i = 2'(d); err_limit_i = ERR_W'(lim); step_ceil_i = STEP_W'(csw);
      dwell_i = DWELL_W'(dw); budget_i = BUDGET_W'(bud); cap_volt_i = cv[0];
      cap_ind_i = ci[0]; cap_tsteps_i = STEP_W'(ts); cap_vsteps_i = STEP_W'(vs);
      start_i = 1;
      @(negedge clk);
      start_i = 0;
      k = 1; trk_bad = 0; bad_act = 0; bad_exp = 0;
      while (!done_o && k <= MAXK) begin
         se = (k - 1) / deff + 1;
         if (!(busy_o && samp_apply_o && samp_dir_o == 2'(d) && int'(samp_offset_o) == se) && !trk_bad) begin
            trk_bad = 1; bad_act = int'(samp_offset_o); bad_exp = se;
         end
         parity_err_i = par_a[k]; recov_entry_i = rec_a[k]; ind_err_i = ind_a[k];
         abort_i = (k == abort_at); start_i = (k == bstart_at);
         if (scramble) begin
            dir_i = 2'($urandom); err_limit_i = ERR_W'($urandom); step_ceil_i = STEP_W'($urandom);
            dwell_i = DWELL_W'($urandom); budget_i = BUDGET_W'($urandom);
            cap_tsteps_i = STEP_W'($urandom); cap_vsteps_i = STEP_W'($urandom);
         end
         @(negedge clk);
         k++;
      end
      parity_err_i = 0; recov_entry_i = 0; ind_err_i = 0; abort_i = 0; start_i = 0;
      chk(!trk_bad, "R1", {tag, " offset track"}, bad_act, bad_exp);
      chk(k - 1 == exp_end, "R5", {tag, " end cycle"}, k - 1, exp_end);
      chk(int'(status_o) == exp_stat, stat_req(exp_stat), {tag, " status"}, int'(status_o), exp_stat);
      chk(int'(margin_o) == exp_margin, stat_req(exp_stat), {tag, " margin"}, int'(margin_o), exp_margin);
      chk(!busy_o && samp_offset_o == 0 && !samp_apply_o, "R8", {tag, " restore"},
          int'(samp_offset_o) + (samp_apply_o ? 100 : 0), 0);
      @(negedge clk);
      chk(!done_o, "R8", {tag, " done single pulse"}, int'(done_o), 0);
   endtask

   task automatic fill(input int pr, input int dw);
      int deff, s;
      deff = (dw == 0) ? 1 : dw;
      for (int k = 0; k <= MAXK; k++) begin
         s = (k == 0) ? 1 : (k - 1) / deff + 1;
         par_a[k] = ($urandom % 100) < s * pr;
         rec_a[k] = ($urandom % 200) < s * pr;
         ind_a[k] = ($urandom % 100) < s * pr;
      end
   endtask

   task automatic clear_pat();
      for (int k = 0; k <= MAXK; k++) begin par_a[k] = 0; rec_a[k] = 0; ind_a[k] = 0; end
      abort_at = 0; bstart_at = 0;
   endtask

   task automatic finish_run();
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL R8 watchdog actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'd20240607));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(!busy_o && !done_o && status_o == 0 && margin_o == 0, "R8", "reset state", int'(status_o), 0);
      chk(samp_offset_o == 0 && !samp_apply_o, "R8", "reset sampler", int'(samp_offset_o), 0);

      // R7: voltage up without capability
      clear_pat();
      sweep(2, 3, 10, 2, 0, 0, 0, 10, 10, 0, "R7 refused");
      // R6: ceiling zero and ceiling limited by capability, no errors
      sweep(0, 3, 0, 2, 0, 1, 0, 10, 10, 0, "R6 zero ceiling");
      sweep(3, 3, 40, 3, 0, 1, 0, 20, 5, 0, "R6 cap ceiling");
      // R5: dwell of zero acts as one cycle
      sweep(1, 2, 7, 0, 0, 1, 0, 9, 9, 0, "R5 dwell zero");
      // R3 R4: limit zero acts as one, failure in first step gives margin 0
      par_a[2] = 1;
      sweep(0, 0, 8, 4, 0, 1, 0, 8, 8, 0, "R3 limit zero");
      // R3: parity+recovery sum, independent sampler pulses ignored
      clear_pat();
      for (int k = 1; k <= 40; k++) ind_a[k] = 1;
      par_a[9] = 1; rec_a[9] = 1;
      sweep(1, 2, 20, 3, 0, 1, 0, 20, 20, 0, "R3 sum errors");
      // R3: independent sampler selected, parity ignored
      clear_pat();
      for (int k = 1; k <= 40; k++) par_a[k] = 1;
      ind_a[5] = 1; ind_a[12] = 1;
      sweep(0, 2, 20, 4, 0, 1, 1, 20, 20, 0, "R3 ind sampler");
      // R3: count cleared between steps (one error per step never reaches 2)
      clear_pat();
      for (int k = 1; k <= 60; k += 3) par_a[k] = 1;
      sweep(0, 2, 6, 3, 0, 1, 0, 6, 6, 0, "R3 per-step clear");
      // R10 R9: abort, stray start while busy
      clear_pat(); abort_at = 11; bstart_at = 4;
      sweep(2, 5, 30, 2, 0, 1, 0, 30, 30, 0, "R10 R9 abort");
      // R11: budget expiry and budget collides with failure
      clear_pat();
      sweep(1, 5, 60, 5, 23, 1, 0, 60, 60, 0, "R11 timeout");
      clear_pat(); par_a[7] = 1;
      sweep(1, 1, 60, 5, 7, 1, 0, 60, 60, 0, "R11 timeout beats fail");
      // R2: config scrambled during sweep
      clear_pat(); par_a[14] = 1; rec_a[14] = 1;
      sweep(0, 2, 30, 3, 0, 1, 0, 30, 30, 1, "R2 frozen cfg");

      for (int n = 0; n < 40; n++) begin
         int d, lim, csw, dw, bud, cv, ci, ts, vs, pr;
         d = $urandom % 4; lim = $urandom % 10; csw = $urandom % 64; dw = $urandom % 9;
         bud = ($urandom % 3 == 0) ? ($urandom % 300 + 1) : 0;
         cv = ($urandom % 4 != 0) ? 1 : 0; ci = $urandom % 2;
         ts = $urandom % 64; vs = $urandom % 64; pr = $urandom % 4;
         fill(pr, dw);
         abort_at = ($urandom % 6 == 0) ? ($urandom % 200 + 1) : 0;
         bstart_at = $urandom % 50 + 1;
         sweep(d, lim, csw, dw, bud, cv, ci, ts, vs, 1, "R2 R9 random");
      end
      finish_run();
   end
endmodule